// File: doc/BRIEF.md
# Dual-Compare PWM Time-Base Generator

This block generates one pulse-width-modulated output from a prescaled time-base counter. The counter runs either as a sawtooth (up only) or as a triangle (up then down) against a programmable period. Two compare values are written through shadow registers and take effect only when the counter passes zero. Six counter events set, clear or toggle the output according to a programmable action word: zero, period, compare A while rising, compare A while falling, compare B while rising and compare B while falling. A separate trigger counts one selected event and raises a sticky interrupt flag on every Nth occurrence.

Software configures the block through a simple write port with a 3-bit address and holds the global run input low while it does so. When run goes high, the counter starts from zero counting up. The counter value and its direction are visible on output ports, so neighbouring logic can follow the waveform.

Top module: `pwm_timebase_gen`

## Requirements
- R1: In sawtooth mode (config bit 0 = 0) the counter steps 0, 1, ... up to the period register (address 0), then returns to 0, so one cycle lasts period+1 ticks.
- R2: In triangle mode (config bit 0 = 1) the counter rises to the period and then falls back to 0. The direction output reads 1 on the ticks after the counter leaves the period value, up to and including its return to 0. It reads 0 otherwise.
- R3: The counter advances once per tick. One tick occurs every H*2^D clocks, where D is config bits [6:4] and H = 1 for config bits [3:1] = 0, otherwise H = 2 * that code (code 5 divides by 10).
- R4: While run is low, the counter reads 0, the direction reads 0, the prescaler restarts, the output keeps its value and both active compares copy their shadows. After reset every output reads 0.
- R5: The action word (address 4) holds six 2-bit fields, each coded 00 keep, 01 drive low, 10 drive high, 11 invert. The fields are zero [1:0], period [3:2], A rising [5:4], A falling [7:6], B rising [9:8] and B falling [11:10]. After reset the word is 0x420 (A rising drives high, B falling drives low).
- R6: Events that coincide in one tick are applied in the order zero, period, A rising, A falling, B rising, B falling, and the last one to change the output wins.
- R7: Writes to compare A (address 2) and compare B (address 3) land in shadows. The active values reload from the shadows only on a tick in which the counter reads 0.
- R8: The interrupt word (address 5) holds enable in bit 0, the source in [3:1] (0 zero, 1 period, 2 A rising, 3 A falling, 4 B rising, 5 B falling) and N in [5:4]. The flag is raised on every Nth occurrence of the selected event.
- R9: The flag stays high until a write to address 6. If an event raises the flag in the same cycle as such a write, the flag stays high.
- R10: The occurrence count restarts at zero whenever the flag is raised or the interrupt is disabled. With N = 0 the flag is never raised.
- R11: A compare match at a turning point belongs to the direction being left: a match at the period counts as rising and a match at 0 after the fall counts as falling.
- R12: Events are evaluated once per tick on the counter value being left. The output therefore changes at the same clock edge at which the counter moves off the matching value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_run | input | 1 | Global time-base run; low holds the counter at zero |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 1 | PWM output |
| irq_flag | output | 1 | Sticky interrupt flag |
| tb_count | output | 16 | Current counter value |
| tb_down | output | 1 | Counter direction, 1 while falling |

## Verification
The hardest case to reach is an interrupt raise that lands in the same clock as a flag-clear write, because the raise depends on the prescaled counter and the occurrence count together. The bench sets N = 1 on the zero event with a short period and holds the clear write asserted for many consecutive cycles. This guarantees several collisions, and a behavioural model checked every clock catches any wrong ordering. Turning-point matches and coincident events are reached by placing compare values exactly at 0, at the period and on top of each other.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;
  localparam int NUM_EV = 6;
  localparam int ACT_W  = 2 * NUM_EV;
  localparam int ADDR_W = 3;

  // event positions, also the application order
  localparam int EV_ZERO = 0;
  localparam int EV_PRD  = 1;
  localparam int EV_A_UP = 2;
  localparam int EV_A_DN = 3;
  localparam int EV_B_UP = 4;
  localparam int EV_B_DN = 5;

  localparam logic [ADDR_W-1:0] REG_PRD  = 3'd0;
  localparam logic [ADDR_W-1:0] REG_CFG  = 3'd1;
  localparam logic [ADDR_W-1:0] REG_CMPA = 3'd2;
  localparam logic [ADDR_W-1:0] REG_CMPB = 3'd3;
  localparam logic [ADDR_W-1:0] REG_ACT  = 3'd4;
  localparam logic [ADDR_W-1:0] REG_INT  = 3'd5;
  localparam logic [ADDR_W-1:0] REG_ICLR = 3'd6;

  localparam logic [ACT_W-1:0] ACT_RESET = 12'h420;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_INV  = 2'b11
  } act_e;

  function automatic logic apply_act(input logic cur, input logic [1:0] code);
    case (act_e'(code))
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      ACT_INV:  return ~cur;
      default:  return cur;
    endcase
  endfunction
endpackage

// File: rtl/pwm_tick_div.sv
module pwm_tick_div #(
  parameter int HS_W = 3,
  parameter int CD_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic [HS_W-1:0] hs_code_i,
  input  logic [CD_W-1:0] cd_code_i,
  output logic            tick_o
);
  localparam int PRE_W = HS_W + 1 + (1 << CD_W) - 1;

  logic [PRE_W-1:0] hs_div;
  logic [PRE_W-1:0] full_div;
  logic [PRE_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (hs_code_i == '0) hs_div = PRE_W'(1);
    else                 hs_div = PRE_W'({hs_code_i, 1'b0});
    full_div = hs_div << cd_code_i;
  end

  assign tick_o = run_i && (cnt_q >= full_div - 1'b1);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)      cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwm_updn_ctr.sv
module pwm_updn_ctr #(
  parameter int CTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             updown_i,
  input  logic [CTR_W-1:0] prd_i,
  output logic [CTR_W-1:0] ctr_o,
  output logic             dir_dn_o
);
  logic [CTR_W-1:0] ctr_q, ctr_d;
  logic             dir_q, dir_d;

  always_comb begin
    ctr_d = ctr_q;
    dir_d = dir_q;
    if (!run_i) begin
      ctr_d = '0;
      dir_d = 1'b0;
    end else if (tick_i) begin
      if (!updown_i) begin
        dir_d = 1'b0;
        ctr_d = (ctr_q >= prd_i) ? '0 : ctr_q + 1'b1;
      end else if (!dir_q) begin
        if (ctr_q >= prd_i) begin
          if (ctr_q != '0) begin
            ctr_d = ctr_q - 1'b1;
            dir_d = 1'b1;
          end
        end else begin
          ctr_d = ctr_q + 1'b1;
        end
      end else begin
        if (ctr_q == '0) begin
          dir_d = 1'b0;
          ctr_d = (prd_i == '0) ? '0 : CTR_W'(1);
        end else begin
          ctr_d = ctr_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_q <= '0;
      dir_q <= 1'b0;
    end else begin
      ctr_q <= ctr_d;
      dir_q <= dir_d;
    end
  end

  assign ctr_o    = ctr_q;
  assign dir_dn_o = dir_q;

  assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !tick_i) |=> $stable(ctr_o));
  assert_idle_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (ctr_o == '0 && !dir_dn_o));
  assert_saw_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tick_i && !updown_i && ctr_o >= prd_i) |=> (ctr_o == '0));
  assert_turn_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tick_i && updown_i && !dir_dn_o && ctr_o == prd_i && prd_i != '0) |=> dir_dn_o);
endmodule

// File: rtl/pwm_act_qual.sv
module pwm_act_qual
  import pwm_tb_pkg::*;
#(
  parameter int CTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CTR_W-1:0] ctr_i,
  input  logic             dir_dn_i,
  input  logic [CTR_W-1:0] prd_i,
  input  logic             wr_cmpa_i,
  input  logic             wr_cmpb_i,
  input  logic [CTR_W-1:0] wdata_i,
  input  logic [ACT_W-1:0] act_i,
  output logic             pwm_o,
  output logic [NUM_EV-1:0] ev_o
);
  logic [CTR_W-1:0] shd_a_q, shd_b_q, act_a_q, act_b_q;
  logic             reload;
  logic [NUM_EV-1:0] ev;
  logic [NUM_EV:0]   stage;
  logic             pwm_q, pwm_d;

  // events sampled on the value being left, once per tick
  always_comb begin
    ev          = '0;
    ev[EV_ZERO] = tick_i && (ctr_i == '0);
    ev[EV_PRD]  = tick_i && (ctr_i == prd_i);
    ev[EV_A_UP] = tick_i && (ctr_i == act_a_q) && !dir_dn_i;
    ev[EV_A_DN] = tick_i && (ctr_i == act_a_q) &&  dir_dn_i;
    ev[EV_B_UP] = tick_i && (ctr_i == act_b_q) && !dir_dn_i;
    ev[EV_B_DN] = tick_i && (ctr_i == act_b_q) &&  dir_dn_i;
  end

  assign stage[0] = pwm_q;
  for (genvar g = 0; g < NUM_EV; g++) begin : g_act_chain
    assign stage[g+1] = ev[g] ? apply_act(stage[g], act_i[2*g +: 2]) : stage[g];
  end

  assign pwm_d  = stage[NUM_EV];
  assign reload = !run_i || ev[EV_ZERO];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shd_a_q <= '0;
    else if (wr_cmpa_i) shd_a_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shd_b_q <= '0;
    else if (wr_cmpb_i) shd_b_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_a_q <= '0;
      act_b_q <= '0;
    end else if (reload) begin
      act_a_q <= shd_a_q;
      act_b_q <= shd_b_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end

  assign pwm_o = pwm_q;
  assign ev_o  = ev;

  assert_pwm_moves_on_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(pwm_o));
  assert_active_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !(tick_i && ctr_i == '0)) |=> ($stable(act_a_q) && $stable(act_b_q)));
endmodule

// File: rtl/pwm_evt_trig.sv
module pwm_evt_trig
  import pwm_tb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic              en_i,
  input  logic [2:0]        src_i,
  input  logic [1:0]        need_i,
  input  logic              clr_i,
  output logic              irq_o
);
  logic [7:0] ev_pad;
  logic       sel_ev;
  logic [1:0] cnt_q, cnt_d;
  logic [2:0] cnt_inc;
  logic       raise;
  logic       irq_q, irq_d;

  assign ev_pad  = {{(8-NUM_EV){1'b0}}, ev_i};
  assign sel_ev  = ev_pad[src_i];
  assign cnt_inc = {1'b0, cnt_q} + 3'd1;

  always_comb begin
    cnt_d = cnt_q;
    raise = 1'b0;
    if (!en_i) begin
      cnt_d = '0;
    end else if (sel_ev && need_i != '0) begin
      if (cnt_inc >= {1'b0, need_i}) begin
        cnt_d = '0;
        raise = 1'b1;
      end else begin
        cnt_d = cnt_inc[1:0];
      end
    end
    irq_d = raise || (irq_q && !clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

  assert_irq_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(sel_ev && en_i));
  assert_count_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (cnt_q == '0));
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clr_i) |=> irq_o);
endmodule

// File: rtl/pwm_timebase_gen.sv
module pwm_timebase_gen
  import pwm_tb_pkg::*;
#(
  parameter int CTR_W = 16,
  parameter int HS_W  = 3,
  parameter int CD_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_run,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CTR_W-1:0]  wr_data,
  output logic              pwm_out,
  output logic              irq_flag,
  output logic [CTR_W-1:0]  tb_count,
  output logic              tb_down
);
  localparam int HS_LO = 1;
  localparam int CD_LO = HS_LO + HS_W;

  logic [CTR_W-1:0] prd_q;
  logic             mode_q;
  logic [HS_W-1:0]  hs_q;
  logic [CD_W-1:0]  cd_q;
  logic [ACT_W-1:0] act_q;
  logic             ien_q;
  logic [2:0]       isrc_q;
  logic [1:0]       need_q;

  logic wr_prd, wr_cfg, wr_cmpa, wr_cmpb, wr_act, wr_int, wr_clr;
  logic tick;
  logic [NUM_EV-1:0] ev;

  assign wr_prd  = wr_en && (wr_addr == REG_PRD);
  assign wr_cfg  = wr_en && (wr_addr == REG_CFG);
  assign wr_cmpa = wr_en && (wr_addr == REG_CMPA);
  assign wr_cmpb = wr_en && (wr_addr == REG_CMPB);
  assign wr_act  = wr_en && (wr_addr == REG_ACT);
  assign wr_int  = wr_en && (wr_addr == REG_INT);
  assign wr_clr  = wr_en && (wr_addr == REG_ICLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prd_q <= '0;
    else if (wr_prd) prd_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      hs_q   <= '0;
      cd_q   <= '0;
    end else if (wr_cfg) begin
      mode_q <= wr_data[0];
      hs_q   <= wr_data[HS_LO +: HS_W];
      cd_q   <= wr_data[CD_LO +: CD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= ACT_RESET;
    else if (wr_act) act_q <= wr_data[ACT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= 1'b0;
      isrc_q <= '0;
      need_q <= '0;
    end else if (wr_int) begin
      ien_q  <= wr_data[0];
      isrc_q <= wr_data[3:1];
      need_q <= wr_data[5:4];
    end
  end

  pwm_tick_div #(.HS_W(HS_W), .CD_W(CD_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (tb_run),
    .hs_code_i (hs_q),
    .cd_code_i (cd_q),
    .tick_o    (tick)
  );

  pwm_updn_ctr #(.CTR_W(CTR_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (tb_run),
    .tick_i   (tick),
    .updown_i (mode_q),
    .prd_i    (prd_q),
    .ctr_o    (tb_count),
    .dir_dn_o (tb_down)
  );

  pwm_act_qual #(.CTR_W(CTR_W)) u_aq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (tb_run),
    .tick_i    (tick),
    .ctr_i     (tb_count),
    .dir_dn_i  (tb_down),
    .prd_i     (prd_q),
    .wr_cmpa_i (wr_cmpa),
    .wr_cmpb_i (wr_cmpb),
    .wdata_i   (wr_data),
    .act_i     (act_q),
    .pwm_o     (pwm_out),
    .ev_o      (ev)
  );

  pwm_evt_trig u_et (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_i   (ev),
    .en_i   (ien_q),
    .src_i  (isrc_q),
    .need_i (need_q),
    .clr_i  (wr_clr),
    .irq_o  (irq_flag)
  );
endmodule

// File: tb/test_pwm_timebase_gen.sv
module test_pwm_timebase_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tb_run;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic        pwm_out;
  logic        irq_flag;
  logic [15:0] tb_count;
  logic        tb_down;

  int    n_chk = 0;
  int    n_err = 0;
  bit    chk_on = 0;
  string phase_tag = "R4";

  // behavioural reference state
  int m_presc, m_ctr, m_prd, m_mode, m_hs, m_cd;
  int m_sha, m_shb, m_aca, m_acb, m_act, m_ien, m_isrc, m_need, m_cnt;
  bit m_dir, m_out, m_flag;

  always #10 clk = ~clk;

  pwm_timebase_gen i_pwm_timebase_gen (
    .clk(clk), .rst_n(rst_n), .tb_run(tb_run), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .irq_flag(irq_flag), .tb_count(tb_count),
    .tb_down(tb_down)
  );

  always @(posedge clk) begin : model_step
    int div;
    bit tk, sel, raise;
    bit [5:0] ev;
    if (!rst_n) begin
      m_presc = 0; m_ctr = 0; m_prd = 0; m_mode = 0; m_hs = 0; m_cd = 0;
      m_sha = 0; m_shb = 0; m_aca = 0; m_acb = 0; m_act = 'h420;
      m_ien = 0; m_isrc = 0; m_need = 0; m_cnt = 0;
      m_dir = 0; m_out = 0; m_flag = 0;
    end else begin
      div = ((m_hs == 0) ? 1 : 2 * m_hs) * (1 << m_cd);
      tk  = tb_run && (m_presc >= div - 1);
      ev[0] = tk && m_ctr == 0;
      ev[1] = tk && m_ctr == m_prd;
      ev[2] = tk && m_ctr == m_aca && !m_dir;
      ev[3] = tk && m_ctr == m_aca && m_dir;
      ev[4] = tk && m_ctr == m_acb && !m_dir;
      ev[5] = tk && m_ctr == m_acb && m_dir;
      for (int i = 0; i < 6; i++)
        if (ev[i])
          case ((m_act >> (2 * i)) & 3)
            1: m_out = 0;
            2: m_out = 1;
            3: m_out = !m_out;
            default: ;
          endcase
      raise = 0;
      sel = (m_isrc < 6) ? ev[m_isrc] : 0;
      if (m_ien == 0) m_cnt = 0;
      else if (sel && m_need != 0) begin
        if (m_cnt + 1 >= m_need) begin m_cnt = 0; raise = 1; end
        else m_cnt = m_cnt + 1;
      end
      if (raise) m_flag = 1;
      else if (wr_en && wr_addr == 6) m_flag = 0;
      if (!tb_run || ev[0]) begin m_aca = m_sha; m_acb = m_shb; end
      if (!tb_run) begin
        m_ctr = 0; m_dir = 0;
      end else if (tk) begin
        if (m_mode == 0) begin
          m_dir = 0; m_ctr = (m_ctr >= m_prd) ? 0 : m_ctr + 1;
        end else if (!m_dir) begin
          if (m_ctr >= m_prd) begin
            if (m_ctr != 0) begin m_ctr = m_ctr - 1; m_dir = 1; end
          end else m_ctr = m_ctr + 1;
        end else begin
          if (m_ctr == 0) begin m_dir = 0; m_ctr = (m_prd == 0) ? 0 : 1; end
          else m_ctr = m_ctr - 1;
        end
      end
      m_presc = (!tb_run || tk) ? 0 : m_presc + 1;
      if (wr_en) begin
        case (wr_addr)
          0: m_prd = wr_data;
          1: begin m_mode = wr_data[0]; m_hs = wr_data[3:1]; m_cd = wr_data[6:4]; end
          2: m_sha = wr_data;
          3: m_shb = wr_data;
          4: m_act = wr_data[11:0];
          5: begin m_ien = wr_data[0]; m_isrc = wr_data[3:1]; m_need = wr_data[5:4]; end
          default: ;
        endcase
      end
    end
  end

  task automatic cmp(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", phase_tag, what, act, exp);
    end
  endtask

  task automatic dchk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // compare against the model every clock, away from the edge
  always @(posedge clk) begin
    #5;
    if (chk_on) begin
      cmp("count", int'(tb_count), m_ctr);
      cmp("direction", int'(tb_down), int'(m_dir));
      cmp("pwm", int'(pwm_out), int'(m_out));
      cmp("irq", int'(irq_flag), int'(m_flag));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_count(input int v);
    while (int'(tb_count) != v) @(negedge clk);
  endtask

  task automatic step_len(output int n);
    int start;
    n = 0;
    start = int'(tb_count);
    while (int'(tb_count) == start && n < 5000) begin @(negedge clk); n++; end
    start = int'(tb_count);
    n = 0;
    while (int'(tb_count) == start && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic restart(input int cfg, input int prd, input int ca, input int cb, input int act);
    @(negedge clk); tb_run = 1'b0;
    wr(1, cfg); wr(0, prd); wr(2, ca); wr(3, cb); wr(4, act);
    @(negedge clk); tb_run = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int len, p0;
    rst_n = 1'b0; tb_run = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    run(3);
    chk_on = 1;
    dchk("R4", "reset count", int'(tb_count), 0);
    dchk("R4", "reset pwm", int'(pwm_out), 0);
    dchk("R4", "reset irq", int'(irq_flag), 0);
    dchk("R4", "reset direction", int'(tb_down), 0);
    @(negedge clk); rst_n = 1'b1;

    // R1 sawtooth, default actions
    phase_tag = "R1";
    wr(0, 9); wr(2, 4); wr(3, 7);
    @(negedge clk); tb_run = 1'b1;
    run(45);
    wait_count(9); @(negedge clk);
    dchk("R1", "wrap after period", int'(tb_count), 0);

    // R3 prescaler
    phase_tag = "R3";
    restart('h0A, 4, 2, 3, 'h420);
    run(60);
    step_len(len);
    dchk("R3", "ticks at divide 10", len, 10);
    wr(1, 'h1A);
    run(50);
    step_len(len);
    dchk("R3", "ticks at divide 20", len, 20);

    // R2 triangle
    phase_tag = "R2";
    restart(1, 6, 2, 4, 'h420);
    run(40);
    while (!(tb_count == 16'd6 && !tb_down)) @(negedge clk);
    @(negedge clk);
    dchk("R2", "count after turn", int'(tb_count), 5);
    dchk("R2", "direction after turn", int'(tb_down), 1);

    // R11 matches at turning points
    phase_tag = "R11";
    wr(2, 6); wr(3, 0);
    run(30);
    wait_count(6); @(negedge clk);
    dchk("R11", "A match at period rising", int'(pwm_out), 1);
    while (!(tb_count == 16'd0 && tb_down)) @(negedge clk);
    @(negedge clk);
    dchk("R11", "B match at zero falling", int'(pwm_out), 0);

    // R7 shadow reload at zero
    phase_tag = "R7";
    restart(0, 19, 15, 0, 'h21);
    run(45);
    wait_count(2);
    wr(2, 5);
    wait_count(10);
    dchk("R7", "old compare still active", int'(pwm_out), 0);
    wait_count(17);
    dchk("R7", "old compare fired", int'(pwm_out), 1);
    wait_count(8);
    dchk("R7", "new compare after zero", int'(pwm_out), 1);

    // R5 action encodings
    phase_tag = "R5";
    restart(0, 4, 1, 3, 'h3);
    run(12);
    wait_count(1); p0 = int'(pwm_out);
    wait_count(0); @(negedge clk);
    dchk("R5", "invert on zero", int'(pwm_out), 1 - p0);
    wr(4, 'h210);
    run(30);

    // R6 coincident events
    phase_tag = "R6";
    restart(0, 4, 0, 2, 'h12);
    run(30);
    dchk("R6", "compare after zero wins", int'(pwm_out), 0);
    wr(3, 4); wr(4, 'h30C);
    run(12);
    p0 = int'(pwm_out);
    run(30);
    dchk("R6", "double inversion", int'(pwm_out), p0);
    wr(2, 2); wr(3, 2); wr(4, 'h120);
    run(30);
    dchk("R6", "B after A", int'(pwm_out), 0);

    // R4 run low
    phase_tag = "R4";
    restart(0, 9, 3, 8, 'h420);
    run(20);
    wait_count(5);
    p0 = int'(pwm_out);
    tb_run = 1'b0;
    wr(2, 6);
    run(5);
    dchk("R4", "count held", int'(tb_count), 0);
    dchk("R4", "pwm held", int'(pwm_out), p0);
    tb_run = 1'b1;
    run(30);

    // R8 interrupt source and divider
    phase_tag = "R8";
    restart(0, 3, 1, 2, 'h420);
    wr(5, 'h13);
    run(20);
    dchk("R8", "period source raised", int'(irq_flag), 1);
    wr(6, 0);
    wr(5, 'h25);
    run(40);
    wr(6, 0);
    wr(5, 'h31);
    run(40);

    // R9 clear colliding with raise
    phase_tag = "R9";
    wr(5, 'h11);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'd6; wr_data = '0;
    run(40);
    wr_en = 1'b0;
    run(20);
    dchk("R9", "flag sticky", int'(irq_flag), 1);

    // R10 counter restart and N = 0
    phase_tag = "R10";
    wr(5, 'h31); wr(6, 0);
    run(5);
    wr(5, 'h30); wr(5, 'h31);
    run(40);
    wr(5, 'h01); wr(6, 0);
    run(40);
    dchk("R10", "never raised with N=0", int'(irq_flag), 0);

    // R12 timing under a divided tick
    phase_tag = "R12";
    restart('h12, 5, 3, 0, 'h21);
    run(30);
    wait_count(3);
    dchk("R12", "pwm before leaving match", int'(pwm_out), 0);
    wait_count(4);
    dchk("R12", "pwm after leaving match", int'(pwm_out), 1);
    run(40);

    chk_on = 0;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule